// File: doc/BRIEF.md
# Channel Bus-In Byte Driver

This block holds the byte that a control unit presents on a channel's inbound data lines, and it produces the parity bit for that byte. An external phase sequencer supplies the current phase number and time slot. In certain phase and slot combinations the register takes a new value from one of three kinds of source:

- a fixed end-of-operation status pattern, used for a fast disconnect;
- an echo of the selected device address;
- one of two data bytes, where a byte-alternation flag picks between the status byte and the command byte.

In every other cycle the register keeps its value.

A load writes every bit of the register. A bit whose selected data is 0 is therefore cleared, even if it was set before. The parity output is odd parity over the held byte and is formed combinationally from it. The cable drivers, the tag lines and the sequencer are outside the block.

Top module: `cbus_in_driver`

## Requirements
- R1: The active-low asynchronous reset `rst_ni` clears the byte to 0. The synchronous `clr_i` (interface reset or init) clears it to 0 on the next edge and wins over any load condition.
- R2: When `phase_i`=0, `slot_i`=0 (time slot 1) and `fast_i`=1, the next byte has bit 6=1, bit 4=1 (control-unit end), bit 5 equal to `dev_end_i`, and all other bits 0.
- R3: When `phase_i`=1 and `slot_i`=1 (time slot 2), the next byte equals `cu_addr_i` (address echo).
- R4: When `phase_i`=6, `slot_i`=0 and `alt_i`=0, the next byte equals `status_i` (first data byte).
- R5: When `phase_i`=6, `slot_i`=0 and `alt_i`=1, the next byte equals `cmd_i` (second data byte).
- R6: A load writes every bit. Bits whose selected data is 0 become 0, even when they were previously 1.
- R7: With no load condition active, the byte holds its value. This covers phase 0 with `fast_i`=0, a matching phase in the wrong slot, and all other phases.
- R8: `par_o` is odd parity over `bus_o`: the 8 bits of `bus_o` plus `par_o` always contain an odd number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear (interface reset or init) |
| phase_i | input | 3 | Current sequencer phase |
| slot_i | input | 1 | Time slot: 0 = slot 1, 1 = slot 2 |
| fast_i | input | 1 | Fast control-unit disconnect response requested |
| dev_end_i | input | 1 | Device-end enable for the disconnect pattern |
| alt_i | input | 1 | Byte-alternation flag: 0 = status byte, 1 = command byte |
| cu_addr_i | input | 8 | Selected control-unit address |
| status_i | input | 8 | Status byte source |
| cmd_i | input | 8 | Command byte source |
| bus_o | output | 8 | Byte driven to the inbound data lines |
| par_o | output | 1 | Odd parity bit for `bus_o` |

## Verification
A wrong load decode shows up at `bus_o` exactly one edge after the offending phase and slot. It appears either as a byte taken from the wrong source or as a value that changed when it should have held. A bit that fails to clear on a load shows up as a stray 1 in the byte that immediately follows an all-ones value. Parity faults are visible in the same cycle as the byte they cover, because `par_o` has no register of its own.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FAST = 2'd1,
    SRC_ECHO = 2'd2,
    SRC_DATA = 2'd3
  } src_e;
endpackage

// File: rtl/cbi_load_decode.sv
module cbi_load_decode
  import cbi_pkg::*;
#(
  parameter int PHASE_W    = 3,
  parameter int FAST_PHASE = 0,
  parameter int ECHO_PHASE = 1,
  parameter int DATA_PHASE = 6
) (
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               slot_i,
  input  logic               fast_i,
  output src_e               src_o
);
  localparam logic [PHASE_W-1:0] PH_FAST = PHASE_W'(FAST_PHASE);
  localparam logic [PHASE_W-1:0] PH_ECHO = PHASE_W'(ECHO_PHASE);
  localparam logic [PHASE_W-1:0] PH_DATA = PHASE_W'(DATA_PHASE);

  always_comb begin
    src_o = SRC_NONE;
    if (phase_i == PH_FAST && !slot_i && fast_i) src_o = SRC_FAST;
    else if (phase_i == PH_ECHO && slot_i)       src_o = SRC_ECHO;
    else if (phase_i == PH_DATA && !slot_i)      src_o = SRC_DATA;
  end
endmodule

// File: rtl/cbi_byte_mux.sv
module cbi_byte_mux
  import cbi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STAT_BIT    = 6,
  parameter int DEV_END_BIT = 5,
  parameter int CU_END_BIT  = 4
) (
  input  src_e              src_i,
  input  logic              dev_end_i,
  input  logic              alt_i,
  input  logic [DATA_W-1:0] cu_addr_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] cmd_i,
  output logic [DATA_W-1:0] d_o,
  output logic              ld_o
);
  logic [DATA_W-1:0] fast_byte;
  logic [DATA_W-1:0] data_byte;

  // fixed disconnect pattern, one bit at a time
  for (genvar i = 0; i < DATA_W; i++) begin : g_fast
    if (i == STAT_BIT || i == CU_END_BIT) begin : g_one
      assign fast_byte[i] = 1'b1;
    end else if (i == DEV_END_BIT) begin : g_dev
      assign fast_byte[i] = dev_end_i;
    end else begin : g_zero
      assign fast_byte[i] = 1'b0;
    end
  end

  assign data_byte = alt_i ? cmd_i : status_i;

  always_comb begin
    unique case (src_i)
      SRC_FAST: d_o = fast_byte;
      SRC_ECHO: d_o = cu_addr_i;
      SRC_DATA: d_o = data_byte;
      default:  d_o = '0;
    endcase
  end

  assign ld_o = (src_i != SRC_NONE);
endmodule

// File: rtl/cbi_bit_store.sv
module cbi_bit_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  // each bit has its own qualified clock enable; absent data resets the bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[i] <= 1'b0;
      else if (clr_i) q_o[i] <= 1'b0;
      else if (ld_i)  q_o[i] <= d_i[i];
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0)); // R1
endmodule

// File: rtl/cbi_parity.sv
module cbi_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] d_i,
  output logic              par_o
);
  logic [DATA_W:0] chain;

  assign chain[0] = 1'b1;  // seed for odd parity
  for (genvar i = 0; i < DATA_W; i++) begin : g_x
    assign chain[i+1] = chain[i] ^ d_i[i];
  end
  assign par_o = chain[DATA_W];
endmodule

// File: rtl/cbus_in_driver.sv
module cbus_in_driver
  import cbi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PHASE_W     = 3,
  parameter int FAST_PHASE  = 0,
  parameter int ECHO_PHASE  = 1,
  parameter int DATA_PHASE  = 6,
  parameter int STAT_BIT    = 6,
  parameter int DEV_END_BIT = 5,
  parameter int CU_END_BIT  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               slot_i,
  input  logic               fast_i,
  input  logic               dev_end_i,
  input  logic               alt_i,
  input  logic [DATA_W-1:0]  cu_addr_i,
  input  logic [DATA_W-1:0]  status_i,
  input  logic [DATA_W-1:0]  cmd_i,
  output logic [DATA_W-1:0]  bus_o,
  output logic               par_o
);
  localparam logic [PHASE_W-1:0] PH_FAST = PHASE_W'(FAST_PHASE);
  localparam logic [PHASE_W-1:0] PH_ECHO = PHASE_W'(ECHO_PHASE);
  localparam logic [PHASE_W-1:0] PH_DATA = PHASE_W'(DATA_PHASE);
  localparam logic [DATA_W-1:0]  FIXED_MASK =
    (DATA_W'(1) << STAT_BIT) | (DATA_W'(1) << CU_END_BIT) | (DATA_W'(1) << DEV_END_BIT);

  src_e              src;
  logic [DATA_W-1:0] nxt;
  logic              ld;

  cbi_load_decode #(
    .PHASE_W(PHASE_W), .FAST_PHASE(FAST_PHASE),
    .ECHO_PHASE(ECHO_PHASE), .DATA_PHASE(DATA_PHASE)
  ) u_dec (
    .phase_i(phase_i), .slot_i(slot_i), .fast_i(fast_i), .src_o(src)
  );

  cbi_byte_mux #(
    .DATA_W(DATA_W), .STAT_BIT(STAT_BIT),
    .DEV_END_BIT(DEV_END_BIT), .CU_END_BIT(CU_END_BIT)
  ) u_mux (
    .src_i(src), .dev_end_i(dev_end_i), .alt_i(alt_i),
    .cu_addr_i(cu_addr_i), .status_i(status_i), .cmd_i(cmd_i),
    .d_o(nxt), .ld_o(ld)
  );

  cbi_bit_store #(.DATA_W(DATA_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .ld_i(ld), .d_i(nxt), .q_o(bus_o)
  );

  cbi_parity #(.DATA_W(DATA_W)) u_par (
    .d_i(bus_o), .par_o(par_o)
  );

  AST_FAST_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && phase_i == PH_FAST && !slot_i && fast_i) |=>
      (bus_o[STAT_BIT] && bus_o[CU_END_BIT] && (bus_o[DEV_END_BIT] == $past(dev_end_i))
       && ((bus_o & ~FIXED_MASK) == '0))); // R2

  AST_ADDR_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && phase_i == PH_ECHO && slot_i) |=> (bus_o == $past(cu_addr_i))); // R3

  AST_FIRST_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && phase_i == PH_DATA && !slot_i && !alt_i) |=> (bus_o == $past(status_i))); // R4

  AST_SECOND_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && phase_i == PH_DATA && !slot_i && alt_i) |=> (bus_o == $past(cmd_i))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(phase_i == PH_FAST && !slot_i && fast_i)
            && !(phase_i == PH_ECHO && slot_i)
            && !(phase_i == PH_DATA && !slot_i)) |=> $stable(bus_o)); // R7

  AST_ODD_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({bus_o, par_o}) % 2) == 1); // R8
endmodule

// File: tb/cbus_in_driver_tb.sv
module cbus_in_driver_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic [2:0] phase = 3'd3;
  logic       slot = 1'b0, fast = 1'b0, dev_end = 1'b0, alt = 1'b0;
  logic [7:0] cu_addr = '0, status = '0, cmd = '0;
  logic [7:0] bus;
  logic       par;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [7:0] b;
    string      r;
  } item_t;
  item_t      q[$];
  logic [7:0] model_q = '0;

  always #4 clk = ~clk;  // 125 MHz

  cbus_in_driver u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .phase_i(phase), .slot_i(slot),
    .fast_i(fast), .dev_end_i(dev_end), .alt_i(alt), .cu_addr_i(cu_addr),
    .status_i(status), .cmd_i(cmd), .bus_o(bus), .par_o(par)
  );

  function automatic logic [7:0] model_next(input logic [7:0] cur);
    if (clr) return 8'h00;                                          // R1
    if (phase == 3'd0 && !slot && fast) return {1'b0, 1'b1, dev_end, 1'b1, 4'h0}; // R2
    if (phase == 3'd1 && slot) return cu_addr;                      // R3
    if (phase == 3'd6 && !slot) return alt ? cmd : status;          // R4 R5
    return cur;                                                     // R7
  endfunction

  task automatic drive(input logic [2:0] ph, input logic sl, input logic fa,
                       input logic de, input logic al, input logic [7:0] ad,
                       input logic [7:0] st, input logic [7:0] cm,
                       input logic cl, input string req);
    @(negedge clk);
    phase = ph; slot = sl; fast = fa; dev_end = de; alt = al;
    cu_addr = ad; status = st; cmd = cm; clr = cl;
    model_q = model_next(model_q);
    q.push_back('{model_q, req});
  endtask

  // monitor: sample after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (bus !== it.b) begin
          fails++;
          $display("FAIL %s bus: actual %h expected %h", it.r, bus, it.b);
        end
        checks++;
        if (par !== ~^it.b) begin
          fails++;
          $display("FAIL R8 parity: actual %b expected %b (byte %h)", par, ~^it.b, it.b);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (bus !== 8'h00 || par !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: actual %h/%b expected 00/1", bus, par);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 fast disconnect with and without device end
    drive(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, "R2");
    drive(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, "R2");
    // R7 phase 0 without fast, and phase 0 in slot 2
    drive(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h5A, 8'h5A, 1'b0, "R7");
    drive(3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h5A, 8'h5A, 1'b0, "R7");
    // R3 echo
    drive(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h11, 8'h22, 1'b0, "R3");
    drive(3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h11, 8'h22, 1'b0, "R7");
    // R4 / R5 data bytes
    drive(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 8'h96, 1'b0, "R4");
    drive(3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hA5, 8'h96, 1'b0, "R5");
    drive(3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0F, 8'hF0, 1'b0, "R7");
    // R6 all ones then a sparse byte: stale ones must clear
    drive(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0, "R4");
    drive(3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 8'h01, 1'b0, "R6");
    drive(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00, 1'b0, "R3");
    drive(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, "R6");
    // R7 other phases hold
    for (int p = 2; p < 8; p++) begin
      if (p != 6) drive(3'(p), 1'b0, 1'b1, 1'b1, 1'b1, 8'h77, 8'h77, 8'h77, 1'b0, "R7");
    end
    // R1 clear, including over a load
    drive(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hE7, 8'h00, 1'b0, "R4");
    drive(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hE7, 8'h00, 1'b1, "R1");
    drive(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 8'h00, 8'h00, 1'b0, "R3");
    drive(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1, "R1");
    // R8 parity sweep through echo loads
    for (int v = 0; v < 256; v += 7) begin
      drive(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'(v), 8'h00, 8'h00, 1'b0, "R8");
    end

    @(negedge clk);
    phase = 3'd3; clr = 1'b0;
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule